// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides an input sample clock by a programmable integer between 1 and 8. Its main output is a one-cycle clock-enable pulse that fires once per divided period. A companion square-wave phase output is high for the first half of each period, rounded up. Downstream logic in the same clock domain uses the enable to sample at the divided rate.

An external, asynchronous SYNC line lets several dividers that share the input clock restart their counters on the same edge. Their divided outputs then stay in lock-step. SYNC is brought into the clock domain by a two-stage synchronizer. Only its rising edge counts, so a long pulse still gives a single restart.

A small parallel write port loads a control word. The word holds the ratio and a two-bit SYNC policy:
- ignore SYNC;
- honour every SYNC edge;
- honour only the first SYNC edge after the write.

A status output shows whether that one-shot permission is still pending.

A new ratio never cuts a period short. It is adopted when the current period ends or when a SYNC restart is accepted, whichever comes first.

Top module: `sync_clk_divider`

## Requirements
- R1: The control word bits [2:0] hold a ratio code c, and the divider divides by N = c + 1. Once a period has started, `div_ce` is high for exactly one cycle out of every N.
- R2: With ratio code 0 (N = 1), `div_ce` and `div_clk` are high in every cycle.
- R3: `div_clk` is high for the first ceil(N/2) cycles of each period, starting in the cycle where `div_ce` is high, and low for the rest of the period.
- R4: `sync_in` passes through two synchronizing flip-flops and is qualified on its rising edge. A level held high for many cycles causes exactly one restart.
- R5: After an accepted restart, `div_ce` is high in the cycle that follows the third rising clock edge at which `sync_in` is sampled high. It then repeats every N cycles.
- R6: With SYNC policy bits [4:3] = 01 (and also 11), every qualified SYNC edge restarts the divider, whatever the current phase.
- R7: With policy 10 (one-shot), a control write arms the divider. The first qualified SYNC edge restarts it and disarms it, and later SYNC edges are ignored until the next write.
- R8: With policy 00, SYNC edges have no effect on the divider outputs.
- R9: A ratio written while the divider runs takes effect at the next period end or at the next accepted restart, whichever comes first. The period in progress is never shortened.
- R10: `oneshot_armed` is high from the cycle after a write selecting policy 10 until an accepted SYNC clears it. A write with any other policy clears it.
- R11: Reset is synchronous and active low. After reset the ratio code is 0, the policy is 00, `oneshot_armed` is low and `div_ce` is high.
- R12: Two dividers fed the same clock, the same settings and the same SYNC produce identical `div_ce` and `div_clk` after the restart, whatever their earlier phases were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe, one cycle |
| cfg_wdata | input | 5 | Control word: [2:0] ratio code, [4:3] SYNC policy |
| sync_in | input | 1 | Asynchronous SYNC request, rising edge acts |
| div_ce | output | 1 | One-cycle enable per divided period |
| div_clk | output | 1 | Divided square wave, high for ceil(N/2) cycles |
| oneshot_armed | output | 1 | One-shot SYNC permission still pending |

## Verification
The assertions assume two things about the inputs. A control write and a qualified SYNC edge never land in the same cycle; if they did, the write would win the armed flag and the disarm check would not apply. `sync_in` is also taken to be a level that the synchronizer can resolve, so the qualified edge is a single-cycle event. The stimulus drives every SYNC pulse and write away from the active clock edge. Writes and SYNC pulses are spaced several cycles apart on planned timelines, so each restart and each ratio change falls at a cycle the expected-value queue already predicts.

// File: rtl/cdiv_pkg.sv
// Shared types for the synchronizable clock divider.
// Assumes nothing beyond a two-bit policy field in the control word.
package cdiv_pkg;

    // SYNC handling policy, decoded from control word bits [4:3]
    typedef enum logic [1:0] {
        SYNC_IGNORE  = 2'b00,
        SYNC_ALWAYS  = 2'b01,
        SYNC_ONESHOT = 2'b10,
        SYNC_ALWAYS2 = 2'b11
    } sync_mode_e;

    // True when the policy restarts on every qualified SYNC edge
    function automatic logic mode_is_always(input sync_mode_e m);
        return (m == SYNC_ALWAYS) || (m == SYNC_ALWAYS2);
    endfunction

endpackage

// File: rtl/cdiv_sync_qual.sv
// Brings an asynchronous SYNC level into the clock domain through
// STAGES flip-flops. It then emits a one-cycle pulse on each rising
// edge of the synchronized level.
// Assumes: sync_async stays high or low for at least one clock period.
module cdiv_sync_qual #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_async,
    output logic sync_rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    // First stage samples the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= sync_async;
    end

    // Remaining synchronizer stages plus one edge-history stage
    genvar g;
    generate
        for (g = 1; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Rising-edge qualification of the synchronized level
    assign sync_rise = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/cdiv_ctrl_reg.sv
// Holds the control word: ratio code and SYNC policy. It also keeps
// the one-shot armed flag and decides whether a qualified SYNC edge
// is accepted as a restart.
// Assumes: a write and a qualified edge in the same cycle are resolved
// in favour of the write for the armed flag.
module cdiv_ctrl_reg
    import cdiv_pkg::*;
#(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W+1:0] wr_data,
    input  logic               sync_rise,
    output logic [RATIO_W-1:0] ratio_code,
    output logic [1:0]         mode_bits,
    output logic               accept,
    output logic               armed
);
    localparam int MODE_LO = RATIO_W;
    localparam int MODE_HI = RATIO_W + 1;

    logic [RATIO_W-1:0] ratio_q;
    logic [1:0]         mode_q;
    logic               armed_q;
    sync_mode_e         mode_e;
    sync_mode_e         wr_mode_e;

    assign mode_e    = sync_mode_e'(mode_q);
    assign wr_mode_e = sync_mode_e'(wr_data[MODE_HI:MODE_LO]);

    // Accept a qualified edge according to the current policy
    always_comb begin
        accept = 1'b0;
        if (sync_rise) begin
            if (mode_is_always(mode_e))                  accept = 1'b1;
            else if (mode_e == SYNC_ONESHOT && armed_q)  accept = 1'b1;
        end
    end

    // Control word storage, loaded by the parallel write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= '0;
            mode_q  <= SYNC_IGNORE;
        end else if (wr_en) begin
            ratio_q <= wr_data[RATIO_W-1:0];
            mode_q  <= wr_data[MODE_HI:MODE_LO];
        end
    end

    // Armed flag: set by a one-shot write, cleared by its accepted SYNC
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (wr_en)
            armed_q <= (wr_mode_e == SYNC_ONESHOT);
        else if (accept && mode_e == SYNC_ONESHOT)
            armed_q <= 1'b0;
    end

    assign ratio_code = ratio_q;
    assign mode_bits  = mode_q;
    assign armed      = armed_q;

endmodule

// File: rtl/cdiv_counter.sv
// Modulo-N phase counter with N = active code + 1. It adopts the
// pending ratio code only at a period end or on a restart, so no
// period is cut short. It drives the enable pulse and the
// half-period square wave.
// Assumes: restart is a single-cycle pulse.
module cdiv_counter #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_code,
    input  logic               restart,
    output logic [RATIO_W-1:0] cnt,
    output logic [RATIO_W-1:0] act_code,
    output logic               tick_ce,
    output logic               phase_clk
);
    localparam int CW = RATIO_W + 1;

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_q;
    logic [CW-1:0]      hi_len;
    logic               wrap;

    assign wrap = (cnt_q == act_q);

    // Phase counter with ratio adoption at wrap or restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (restart || wrap) begin
            cnt_q <= '0;
            act_q <= ratio_code;
        end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
        end
    end

    // High-phase length ceil(N/2) = (code + 2) / 2
    assign hi_len = ({1'b0, act_q} + CW'(2)) >> 1;

    // Output decode from the registered phase
    assign tick_ce   = (cnt_q == '0);
    assign phase_clk = ({1'b0, cnt_q} < hi_len);

    assign cnt      = cnt_q;
    assign act_code = act_q;

endmodule

// File: rtl/sync_clk_divider.sv
// Top level of the synchronizable integer clock divider. It joins the
// SYNC qualifier, the control register and the phase counter.
// Assumes: every input is synchronous to clk except sync_in.
module sync_clk_divider #(
    parameter int RATIO_W     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [RATIO_W+1:0] cfg_wdata,
    input  logic               sync_in,
    output logic               div_ce,
    output logic               div_clk,
    output logic               oneshot_armed
);
    logic               sync_rise;
    logic               accept;
    logic [RATIO_W-1:0] ratio_code;
    logic [1:0]         mode_q;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_code;

    cdiv_sync_qual #(.STAGES(SYNC_STAGES)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_async (sync_in),
        .sync_rise  (sync_rise)
    );

    cdiv_ctrl_reg #(.RATIO_W(RATIO_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_data    (cfg_wdata),
        .sync_rise  (sync_rise),
        .ratio_code (ratio_code),
        .mode_bits  (mode_q),
        .accept     (accept),
        .armed      (oneshot_armed)
    );

    cdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .restart    (accept),
        .cnt        (cnt_q),
        .act_code   (act_code),
        .tick_ce    (div_ce),
        .phase_clk  (div_clk)
    );

endmodule

// File: rtl/cdiv_checker.sv
// Property checker for sync_clk_divider, attached by bind.
// Assumes: no control write in the same cycle as a qualified SYNC edge.
module cdiv_checker #(
    parameter int RATIO_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [RATIO_W+1:0] cfg_wdata,
    input logic               sync_rise,
    input logic               accept,
    input logic [RATIO_W-1:0] cnt,
    input logic [RATIO_W-1:0] act,
    input logic [RATIO_W-1:0] ratio_code,
    input logic [1:0]         mode,
    input logic               ce,
    input logic               dclk,
    input logic               armed
);
    // R1: phase never passes the active terminal count
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act);

    // R2: divide-by-one keeps the enable high
    p_ratio1_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> ce);

    // R3: square wave is high in the enable cycle
    p_dclk_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> dclk);

    // R4: a qualified edge lasts one cycle
    p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> !sync_rise);

    // R5: an accepted SYNC restarts the phase and loads the ratio
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cnt == '0 && act == $past(ratio_code)));

    // R7: a one-shot restart disarms
    p_once_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == 2'b10 && !cfg_we) |=> !armed);

    // R8: with SYNC ignored the counter keeps counting
    p_ignore_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rise && mode == 2'b00 && !cfg_we && cnt != act)
        |=> (cnt == $past(cnt) + RATIO_W'(1)));

    // R9: the active ratio only changes at wrap or restart
    p_no_runt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && cnt != act) |=> $stable(act));

    // R10: a one-shot write arms the flag
    p_write_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[RATIO_W+1:RATIO_W] == 2'b10) |=> armed);

endmodule

bind sync_clk_divider cdiv_checker #(.RATIO_W(RATIO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .sync_rise  (sync_rise),
    .accept     (accept),
    .cnt        (cnt_q),
    .act        (act_code),
    .ratio_code (ratio_code),
    .mode       (mode_q),
    .ce         (div_ce),
    .dclk       (div_clk),
    .armed      (oneshot_armed)
);

// File: tb/sim_sync_clk_divider.sv
`timescale 1ns/1ps
module sim_sync_clk_divider;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we0 = 1'b0;
    logic          we1 = 1'b0;
    logic [RW+1:0] wdata = '0;
    logic          sync_in = 1'b0;
    logic          ce0, dclk0, arm0, ce1, dclk1, arm1;

    always #2 clk = ~clk;   // 250 MHz

    sync_clk_divider #(.RATIO_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(we0), .cfg_wdata(wdata),
        .sync_in(sync_in), .div_ce(ce0), .div_clk(dclk0), .oneshot_armed(arm0));

    sync_clk_divider #(.RATIO_W(RW)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(we1), .cfg_wdata(wdata),
        .sync_in(sync_in), .div_ce(ce1), .div_clk(dclk1), .oneshot_armed(arm1));

    int    q[$];
    int    n_chk = 0;
    int    n_err = 0;
    int    t = 0;
    bit    done = 1'b0;
    string cur_req = "R0";

    // Monitor: pops one expected {div_clk,div_ce} per cycle; -1 = don't care
    always @(negedge clk) begin
        int e;
        if (q.size() > 0) begin
            e = q.pop_front();
            if (e >= 0) begin
                n_chk++;
                if ({dclk0, ce0} != e[1:0]) begin
                    n_err++;
                    $display("FAIL %s: {div_clk,div_ce} got %b expected %b at %0t",
                             cur_req, {dclk0, ce0}, e[1:0], $time);
                end
            end
        end
    end

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #1; t++;
    endtask

    task automatic goto(int tgt);
        while (t < tgt) step();
    endtask

    // Wait for the scoreboard to drain, then open a new timeline at t = 0
    task automatic start_tl();
        while (q.size() != 0) @(negedge clk);
        @(posedge clk); #1; t = 0;
    endtask

    task automatic push_dc(int k);
        for (int i = 0; i < k; i++) q.push_back(-1);
    endtask

    // Expected pattern for divide-by-n starting at phase 0
    task automatic push_run(int n, int len);
        for (int i = 0; i < len; i++) begin
            int c;
            c = i % n;
            q.push_back(((c < (n + 1) / 2) ? 2 : 0) + ((c == 0) ? 1 : 0));
        end
    endtask

    task automatic wr(bit sel, int code, logic [1:0] mode);
        wdata = {mode, RW'(code)};
        if (sel) we1 = 1'b1; else we0 = 1'b1;
        step();
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic pulse();
        sync_in = 1'b1; step(); sync_in = 1'b0;
    endtask

    task automatic chk_arm(int i, string req, int exp);
        goto(i);
        @(negedge clk);
        chk(req, arm0, exp);
        @(posedge clk); #1; t++;
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ce", ce0, 1);
        chk("R11 dclk", dclk0, 1);
        chk("R11 armed", arm0, 0);

        // R1 R3 R4 R5: divide by 4, SYNC held high gives one restart
        start_tl(); wr(0, 3, 2'b01);
        start_tl(); cur_req = "R4/R5/R1/R3";
        push_dc(3); push_run(4, 14);
        sync_in = 1'b1; goto(12); sync_in = 1'b0;

        // R6: a second SYNC at another phase restarts again
        start_tl(); cur_req = "R6";
        push_dc(3); push_run(4, 7); push_run(4, 8);
        pulse(); goto(7); pulse();

        // R8: policy 00 ignores SYNC
        start_tl(); cur_req = "R8";
        push_dc(3); push_run(4, 20);
        pulse(); goto(5); wr(0, 3, 2'b00); goto(10); pulse();

        // R7 R10: one-shot arming, single restart, re-arm by write
        start_tl(); wr(0, 2, 2'b01);
        start_tl(); cur_req = "R7";
        push_dc(3); push_run(3, 10); push_run(3, 19); push_run(3, 9);
        pulse();
        goto(5); wr(0, 2, 2'b10);
        chk_arm(7, "R10 armed after write", 1);
        goto(10); pulse();
        chk_arm(14, "R10 disarmed by sync", 0);
        goto(20); pulse();
        chk_arm(25, "R7 stays disarmed", 0);
        wr(0, 2, 2'b10);
        chk_arm(28, "R10 re-armed", 1);
        pulse();
        chk_arm(33, "R7 second disarm", 0);

        // R9: new ratio adopted at the period end
        start_tl(); wr(0, 3, 2'b01);
        start_tl(); cur_req = "R9 wrap";
        push_dc(3); push_run(4, 4); push_run(2, 10);
        pulse(); goto(4); wr(0, 1, 2'b01);

        // R1 R9: divide by 8, then new ratio adopted at a restart
        start_tl(); wr(0, 7, 2'b01);
        start_tl(); cur_req = "R1/R9 sync";
        push_dc(3); push_run(8, 21); push_run(5, 15);
        pulse(); goto(20); wr(0, 4, 2'b01); pulse();

        // R2: divide by one
        start_tl(); wr(0, 0, 2'b01);
        start_tl(); cur_req = "R2";
        push_dc(3); push_run(1, 10);
        pulse();

        // R12: two dividers in different phases line up after SYNC
        start_tl(); wr(0, 5, 2'b01); step(); step(); wr(1, 5, 2'b01);
        start_tl(); cur_req = "R12";
        push_dc(3); push_run(6, 12);
        pulse();
        for (int i = 3; i < 15; i++) begin
            goto(i);
            @(negedge clk);
            chk("R12 lockstep", {dclk1, ce1}, {dclk0, ce0});
            @(posedge clk); #1; t++;
        end

        start_tl();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule